// File: doc/BRIEF.md
# Two-Wire Write-Word Slave for a 10-Bit Converter

This block is the serial control front end of a 10-bit converter. It watches a two-wire bus, SCL as clock and SDA as data with open-drain signalling, by oversampling both lines with the system clock. It recognises its own 7-bit address, then accepts a command byte and a two-byte code. It acknowledges each accepted byte by pulling SDA low.

The code is held in an input latch and copied to the output latch at one of two moments. The first is any STOP on the bus. The second is the acknowledge of a shared sync address that many devices answer at once. The command byte selects which of the two applies, requests power-down and selects the reference.

Transfers cut short by a START or STOP are handled so that a command byte already acknowledged survives. Any data bytes received with it are dropped.

Top module: `smbus_dac_if`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 0100000) and whose last bit is 0 (write) is acknowledged. Any other address, including DEV_ADDR with the read bit 1, is not acknowledged, and every byte after it is ignored and not acknowledged until the next START.
- R2: The byte after a matching address is the command byte and is always acknowledged. Bit 0 selects the sync update mode, bit 1 requests shutdown and bit 2 selects the internal reference. Bits 7 to 3 have no effect.
- R3: The second byte after the address sets code bits 7..0, and bits 1..0 of the third byte set code bits 9..8. Bits 7..2 of the third byte are ignored. Both bytes are acknowledged, and any further byte in the same transfer is not acknowledged and has no effect.
- R4: With the sync mode bit 0, a STOP copies the input latch to `code_o`. `code_o` does not change before that STOP.
- R5: With the sync mode bit 1, a STOP leaves `code_o` unchanged. The input latch is copied to `code_o` on the rising SCL edge of the acknowledge bit of an address byte whose upper seven bits equal SYNC_ADDR, before any STOP.
- R6: A SYNC_ADDR address byte is acknowledged only while the sync mode bit is 1. Otherwise it is not acknowledged and changes no output.
- R7: `shdn_o` takes the value of the shutdown request bit at every STOP and at no other time. `code_o` is kept while shut down.
- R8: `ref_int_o` follows the reference bit as soon as the command byte is acknowledged, without waiting for STOP.
- R9: A START or STOP after the command byte's acknowledge but before the acknowledge of the third byte keeps the new command and discards the received data bytes.
- R10: A START or STOP before the command byte's acknowledge discards the partial command, so the previous command bits stay in force.
- R11: After reset `code_o` is 0, `shdn_o` is 0, `ref_int_o` is 0, the sync mode bit is 0 and SDA is released.
- R12: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA changes while SCL is low are data, and the slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | High to pull SDA low for an acknowledge |
| code_o | output | CODE_W | Output latch code for the converter |
| shdn_o | output | 1 | Power-down state |
| ref_int_o | output | 1 | 1 selects the internal reference, 0 the supply |

## Verification
The hardest case to reach is an update from the sync address in sync mode. It requires a full word written in sync mode, a STOP that must leave the output alone, and a second transfer whose address acknowledge moves the code before its STOP. The bench builds this sequence from its byte-level tasks. Its model updates the expected code at the moment it raises SCL for that acknowledge, and compares on every clock, so an update at STOP would be caught. Interrupted transfers are reached with a partial-byte task that clocks only some bits before a START or STOP.

// File: rtl/smbus_dac_if.sv
module smbus_dac_if #(
  parameter logic [6:0] DEV_ADDR  = 7'b0100000,
  parameter logic [6:0] SYNC_ADDR = 7'b0001100,
  parameter int         CODE_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [CODE_W-1:0] code_o,
  output logic              shdn_o,
  output logic              ref_int_o
);
  localparam int HI_W = CODE_W - 8;

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_CMD, P_LO, P_HI, P_SKIP} ph_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  ph_t        ph;
  logic [3:0] cnt;
  logic [7:0] sh, lo_q;
  logic [CODE_W-1:0] in_q, code_q;
  logic       sy_q, sd_q, bg_q, shdn_q, pull_q, sync_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire active   = (ph != P_IDLE);
  wire dev_hit  = (sh[7:1] == DEV_ADDR) && !sh[0];
  wire sync_hit = (sh[7:1] == SYNC_ADDR) && sy_q;
  wire sync_fire = active && scl_rise && (cnt == 4'd8) && sync_q;

  assign sda_pull_o = pull_q;
  assign code_o     = code_q;
  assign shdn_o     = shdn_q;
  assign ref_int_o  = bg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      cnt    <= '0;
      sh     <= '0;
      lo_q   <= '0;
      in_q   <= '0;
      code_q <= '0;
      sy_q   <= 1'b0;
      sd_q   <= 1'b0;
      bg_q   <= 1'b0;
      shdn_q <= 1'b0;
      pull_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (stop_c) begin
      ph     <= P_IDLE;
      cnt    <= '0;
      pull_q <= 1'b0;
      sync_q <= 1'b0;
      shdn_q <= sd_q;
      if (!sy_q) code_q <= in_q;
    end else if (start_c) begin
      ph     <= P_ADDR;
      cnt    <= '0;
      pull_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (active && scl_rise) begin
      if (cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (cnt == 4'd8) begin
        cnt <= 4'd9;
        if (sync_q) code_q <= in_q;
      end
    end else if (active && scl_fall) begin
      if (cnt == 4'd8) begin
        unique case (ph)
          P_ADDR: begin
            pull_q <= dev_hit | sync_hit;
            sync_q <= sync_hit & ~dev_hit;
            ph     <= dev_hit ? P_CMD : P_SKIP;
          end
          P_CMD: begin
            pull_q <= 1'b1;
            {bg_q, sd_q, sy_q} <= sh[2:0];
            ph     <= P_LO;
          end
          P_LO: begin
            pull_q <= 1'b1;
            lo_q   <= sh;
            ph     <= P_HI;
          end
          P_HI: begin
            pull_q <= 1'b1;
            in_q   <= {sh[HI_W-1:0], lo_q};
            ph     <= P_SKIP;
          end
          default: pull_q <= 1'b0;
        endcase
      end else if (cnt == 4'd9) begin
        pull_q <= 1'b0;
        sync_q <= 1'b0;
        cnt    <= '0;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE) |-> !sda_pull_o);

  assert_code_only_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_c || sync_fire) |=> $stable(code_o));

  assert_stop_keeps_code_in_sync_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && sy_q) |=> $stable(code_o));

  assert_sync_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |-> sy_q);

  assert_shdn_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_c |=> $stable(shdn_o));

  assert_pull_steady_scl_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |=> $stable(sda_pull_o));

  assert_start_restarts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (ph == P_ADDR) && (cnt == 4'd0) && !sda_pull_o);
endmodule

// File: tb/test_smbus_dac_if.sv
module test_smbus_dac_if;
  localparam logic [6:0] DEV  = 7'b0100000;
  localparam logic [6:0] SYNC = 7'b0001100;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  wire        pull;
  wire [9:0]  code;
  wire        shdn, refi;
  wire        sda_line = m_sda & ~pull;

  int checks = 0, errors = 0, hold = 0;
  bit run_cmp = 0, done = 0;
  logic [9:0] exp_code = '0, m_in = '0;
  logic       exp_shdn = 0, exp_ref = 0, m_sy = 0, m_sd = 0;
  logic [7:0] m_lo = '0;
  int         mph = 0;

  smbus_dac_if i_smbus_dac_if (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .code_o(code), .shdn_o(shdn), .ref_int_o(refi));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  always @(negedge clk) if (run_cmp) begin
    if (hold > 0) hold--;
    else begin
      chk("R4/R5 code_o", code, exp_code);
      chk("R7 shdn_o", shdn, exp_shdn);
      chk("R8 ref_int_o", refi, exp_ref);
    end
  end

  task automatic do_start();
    m_sda = 1; wt(8); scl = 1; wt(8); m_sda = 0; wt(8); scl = 0; wt(8);
    mph = 1;
  endtask

  task automatic do_stop();
    m_sda = 0; wt(8); scl = 1; wt(8); m_sda = 1;
    if (!m_sy) exp_code = m_in;
    exp_shdn = m_sd; hold = 8; mph = 0;
    wt(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wt(8); scl = 1; wt(8); scl = 0; wt(8);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, input string tag);
    bit eack = 0, fire = 0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(8); scl = 1; wt(8); scl = 0;
      if (i != 0) wt(8);
    end
    case (mph)
      1: begin
        if (b[7:1] == DEV && !b[0]) begin eack = 1; mph = 2; end
        else if (b[7:1] == SYNC && m_sy) begin eack = 1; fire = 1; mph = 5; end
        else mph = 5;
      end
      2: begin eack = 1; m_sy = b[0]; m_sd = b[1]; exp_ref = b[2]; hold = 8; mph = 3; end
      3: begin eack = 1; m_lo = b; mph = 4; end
      4: begin eack = 1; m_in = {b[1:0], m_lo}; mph = 5; end
      default: eack = 0;
    endcase
    m_sda = 1; wt(8); scl = 1;
    if (fire) begin exp_code = m_in; hold = 8; end
    wt(4);
    chk(tag, !sda_line, eack);
    wt(4); scl = 0; wt(8);
  endtask

  task automatic word(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    xbyte(c, "R2 command ack");
    xbyte(lo, "R3 low byte ack");
    xbyte(hi, "R3 high byte ack");
  endtask

  initial begin
    wt(5);
    rst_n = 1;
    wt(2);
    chk("R11 reset code", code, 0);
    chk("R11 reset shdn", shdn, 0);
    chk("R11 reset ref", refi, 0);
    chk("R11 reset sda released", pull, 0);
    run_cmp = 1;

    do_start();
    xbyte({DEV, 1'b0}, "R1 R12 address ack");
    xbyte(8'h00, "R2 command ack");
    xbyte(8'hA5, "R3 low byte ack");
    xbyte(8'hFE, "R3 high byte ack");
    chk("R4 code held before STOP", code, 0);
    do_stop();
    wt(4);
    chk("R3 R4 code after STOP", code, 10'h2A5);

    word(8'hF8, 8'h3C, 8'h01);
    xbyte(8'h77, "R3 extra byte nack");
    do_stop();
    wt(4);
    chk("R2 R3 upper command bits ignored", code, 10'h13C);

    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    xbyte(8'h04, "R2 command ack");
    wt(4);
    chk("R8 reference before STOP", refi, 1);
    do_stop();

    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    xbyte(8'h06, "R2 command ack");
    wt(4);
    chk("R7 shdn waits for STOP", shdn, 0);
    do_stop();
    wt(4);
    chk("R7 shdn at STOP", shdn, 1);
    chk("R7 code kept in shutdown", code, 10'h13C);

    word(8'h01, 8'h55, 8'h03);
    do_stop();
    wt(4);
    chk("R5 STOP does not update in sync mode", code, 10'h13C);
    do_start();
    xbyte({SYNC, 1'b0}, "R6 sync address ack");
    wt(4);
    chk("R5 sync update before STOP", code, 10'h355);
    do_stop();

    word(8'h00, 8'h11, 8'h00);
    do_stop();
    do_start();
    xbyte({SYNC, 1'b0}, "R6 sync nack when mode off");
    do_stop();
    wt(4);
    chk("R6 no update from nacked sync", code, 10'h011);

    do_start();
    xbyte({7'h21, 1'b0}, "R1 foreign address nack");
    xbyte(8'h04, "R1 ignored after nack");
    do_stop();
    do_start();
    xbyte({DEV, 1'b1}, "R1 read bit nack");
    xbyte(8'h04, "R1 ignored after read nack");
    do_stop();
    wt(4);
    chk("R1 ignored bytes leave reference", refi, 0);

    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    xbyte(8'h04, "R9 command ack");
    xbyte(8'hFF, "R9 low byte ack");
    do_stop();
    wt(4);
    chk("R9 command kept", refi, 1);
    chk("R9 data discarded", code, 10'h011);

    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    send_bits(8'h00, 7);
    do_stop();
    wt(4);
    chk("R10 partial command discarded", refi, 1);

    do_start();
    xbyte({DEV, 1'b0}, "R1 address ack");
    xbyte(8'h00, "R9 command ack");
    xbyte(8'h22, "R9 low byte ack");
    send_bits(8'hFF, 5);
    do_start();
    xbyte({DEV, 1'b0}, "R9 address after repeated start");
    do_stop();
    wt(4);
    chk("R9 repeated start drops data", code, 10'h011);
    chk("R9 repeated start keeps command", refi, 0);

    wt(20);
    run_cmp = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wt(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule